// File: doc/BRIEF.md
# Radar Corner-Turn Transpose Controller

This block reorders a radar data frame so that a slow-time (Doppler) FFT can run on it. Samples arrive one pulse at a time, with every range bin of a pulse in sequence. The block writes them to external memory in that row order, using bursts. It then reads the frame back column by column. For each range bin it fetches that bin from every pulse, first pulse to last, and then moves on to the next range bin. Each sample is a 24-bit word that holds an in-phase part and a quadrature part.

Two frame areas in memory take turns. While one frame is being read out in transposed order, the next frame can be written into the other area. A frame area is read only after the last write beat of its frame has been accepted. It is handed back to the writer only after the last read response of that frame has come back. Both sides of the block take backpressure without losing data. A stalled output stops new read requests. A stalled memory port stops input acceptance.

The memory port carries one beat per handshake. A write burst is a run of beats at consecutive addresses, and its first beat is flagged and carries the burst length. A read is a single beat of length one. Read data returns on a separate response channel in request order, one response per read.

Top module: `corner_turn_ctrl`

## Requirements
- R1: A sample is packed as I in bits 23:12 and Q in bits 11:0. Every sample reaches the output unchanged.
- R2: Frame sample (pulse p, range r) is written to address base + p*NUM_RANGE + r. Writes are issued in arrival order, so consecutive write beats have consecutive addresses. The input markers agree with this count: start-of-pulse comes at r = 0, and end-of-frame comes at the last sample.
- R3: Writes go out as bursts. The first beat has mem_req_first high and mem_req_len set to the burst length. A burst is never longer than BURST_LEN and never crosses a pulse boundary. Its length is min(BURST_LEN, NUM_RANGE - r), where r is the range index of its first beat.
- R4: Reads are single-word requests (mem_req_we low, length 1). They are issued in transposed order: for range bin r, pulses 0 to NUM_PULSE-1, then bin r+1. The address is base + p*NUM_RANGE + r.
- R5: No read of a frame is issued before the last write beat of that frame has been accepted by the memory port.
- R6: Frame k uses base BASE0 when k is even and BASE1 when k is odd. While both frame areas hold unread or partly read frames, in_ready stays low.
- R7: out_sob is high on the pulse-0 sample of each range bin. out_eof is high only on the final sample of the frame.
- R8: The number of outstanding reads plus the number of buffered output words never exceeds OUT_DEPTH. While out_valid is high and out_ready is low, out_data holds its value.
- R9: While the memory port refuses beats, at most BURST_LEN samples are accepted and in_ready then stays low. No sample is lost, and a pending write beat holds its address and data.
- R10: frame_done is a one-cycle pulse after the last read response of a frame. It comes no later than the output of that frame's end-of-frame sample.
- R11: After reset: in_ready high, mem_req_valid low, out_valid low, frame_done low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample valid |
| in_ready | output | 1 | Input sample accepted when high with in_valid |
| in_data | input | 24 | Input sample, I in 23:12, Q in 11:0 |
| in_sop | input | 1 | First sample of a pulse |
| in_eof | input | 1 | Last sample of a frame |
| mem_req_valid | output | 1 | Memory request beat valid |
| mem_req_ready | input | 1 | Memory accepts the beat |
| mem_req_we | output | 1 | 1 = write beat, 0 = read request |
| mem_req_first | output | 1 | First beat of a write burst, or a read request |
| mem_req_len | output | $clog2(BURST_LEN+1) | Burst length in words (1 for reads) |
| mem_req_addr | output | ADDR_W | Word address |
| mem_req_wdata | output | 24 | Write data |
| mem_rsp_valid | input | 1 | Read response valid, in request order |
| mem_rsp_data | input | 24 | Read response data |
| out_valid | output | 1 | Output sample valid |
| out_ready | input | 1 | Downstream accepts the sample |
| out_data | output | 24 | Transposed sample |
| out_sob | output | 1 | First sample of a range bin (pulse 0) |
| out_eof | output | 1 | Last sample of a frame |
| frame_done | output | 1 | One-cycle pulse when all reads of a frame have returned |

## Verification
The assertions take three things for granted about the environment. The input markers agree with the block's own pulse and range count. The memory applies requests in acceptance order. The memory returns exactly one in-order response per read and never a response with no read outstanding. The bench keeps within these limits in three ways. Its sender derives in_sop and in_eof from the same loop indices that produce the samples. Its memory model commits writes at the accepting edge. Its memory model answers each read through a fixed two-stage pipeline.

// File: rtl/ct_pkg.sv
package ct_pkg;

    localparam int SAMPLE_W = 24;
    localparam int PART_W   = 12;

    typedef struct packed {
        logic [PART_W-1:0] i;
        logic [PART_W-1:0] q;
    } iq_t;

    typedef struct packed {
        iq_t  s;
        logic sob;
        logic eof;
    } out_word_t;

    typedef enum logic {
        WR_FILL  = 1'b0,
        WR_DRAIN = 1'b1
    } wr_state_e;

    function automatic int unsigned idx_w(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/ct_bank_ctrl.sv
module ct_bank_ctrl (
    input  logic clk,
    input  logic rst,
    input  logic commit,
    input  logic release_i,
    output logic wr_bank,
    output logic wr_free,
    output logic rd_bank,
    output logic rd_ready
);

    logic [1:0] full;

    always_ff @(posedge clk) begin
        if (rst) begin
            full    <= '0;
            wr_bank <= 1'b0;
            rd_bank <= 1'b0;
        end else begin
            if (commit) begin
                full[wr_bank] <= 1'b1;
                wr_bank       <= ~wr_bank;
            end
            if (release_i) begin
                full[rd_bank] <= 1'b0;
                rd_bank       <= ~rd_bank;
            end
        end
    end

    always_comb begin
        wr_free  = ~full[wr_bank];
        rd_ready = full[rd_bank];
    end

    // R6
    commit_free_chk: assert property (@(posedge clk) disable iff (rst)
        commit |-> !full[wr_bank]);

    // R6
    release_full_chk: assert property (@(posedge clk) disable iff (rst)
        release_i |-> full[rd_bank]);

endmodule

// File: rtl/ct_write_path.sv
module ct_write_path
    import ct_pkg::*;
#(
    parameter int NUM_RANGE = 4096,
    parameter int NUM_PULSE = 512,
    parameter int BURST_LEN = 16,
    parameter int ADDR_W    = 32
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         in_valid,
    output logic                         in_ready,
    input  iq_t                          in_data,
    input  logic                         in_sop,
    input  logic                         in_eof,
    input  logic [ADDR_W-1:0]            bank_base,
    input  logic                         bank_free,
    output logic                         commit,
    output logic                         wr_valid,
    input  logic                         wr_ready,
    output logic                         wr_first,
    output logic [$clog2(BURST_LEN+1)-1:0] wr_len,
    output logic [ADDR_W-1:0]            wr_addr,
    output iq_t                          wr_data
);

    localparam int FRAME = NUM_RANGE * NUM_PULSE;
    localparam int RW    = idx_w(NUM_RANGE);
    localparam int PW    = idx_w(NUM_PULSE);
    localparam int FW    = idx_w(FRAME);
    localparam int LW    = $clog2(BURST_LEN + 1);
    localparam int BW    = idx_w(BURST_LEN);

    wr_state_e       state;
    iq_t             stage [BURST_LEN];
    logic [LW-1:0]   fill_cnt;
    logic [LW-1:0]   beat;
    logic            seg_end;
    logic [RW-1:0]   in_r;
    logic [PW-1:0]   in_p;
    logic [FW-1:0]   wr_lin;
    logic            accept;
    logic            burst_go;
    logic            beat_ok;
    logic            last_beat;

    always_comb begin
        in_ready  = (state == WR_FILL) && (fill_cnt != LW'(BURST_LEN)) && !seg_end && bank_free;
        accept    = in_valid && in_ready;
        burst_go  = (state == WR_FILL) && ((fill_cnt == LW'(BURST_LEN)) || seg_end);
        wr_valid  = (state == WR_DRAIN);
        wr_first  = (beat == '0);
        wr_len    = fill_cnt;
        wr_addr   = bank_base + ADDR_W'(wr_lin);
        wr_data   = stage[beat[BW-1:0]];
        beat_ok   = wr_valid && wr_ready;
        last_beat = (beat == fill_cnt - 1'b1);
        commit    = beat_ok && last_beat && (wr_lin == FW'(FRAME - 1));
    end

    always_ff @(posedge clk) begin
        if (accept) begin
            stage[fill_cnt[BW-1:0]] <= in_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= WR_FILL;
            fill_cnt <= '0;
            beat     <= '0;
            seg_end  <= 1'b0;
            in_r     <= '0;
            in_p     <= '0;
            wr_lin   <= '0;
        end else begin
            if (accept) begin
                fill_cnt <= fill_cnt + 1'b1;
                if (in_r == RW'(NUM_RANGE - 1)) begin
                    in_r    <= '0;
                    seg_end <= 1'b1;
                    in_p    <= (in_p == PW'(NUM_PULSE - 1)) ? '0 : in_p + 1'b1;
                end else begin
                    in_r <= in_r + 1'b1;
                end
            end
            if (burst_go) begin
                state <= WR_DRAIN;
                beat  <= '0;
            end
            if (beat_ok) begin
                wr_lin <= (wr_lin == FW'(FRAME - 1)) ? '0 : wr_lin + 1'b1;
                if (last_beat) begin
                    state    <= WR_FILL;
                    fill_cnt <= '0;
                    beat     <= '0;
                    seg_end  <= 1'b0;
                end else begin
                    beat <= beat + 1'b1;
                end
            end
        end
    end

    // R3
    burst_len_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && wr_first) |-> (wr_len != '0 && wr_len <= LW'(BURST_LEN)));

    // R9
    wr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data)));

    // R2
    sop_align_chk: assert property (@(posedge clk) disable iff (rst)
        (accept && in_sop) |-> (in_r == '0));

    // R2
    eof_align_chk: assert property (@(posedge clk) disable iff (rst)
        (accept && in_eof) |-> (in_r == RW'(NUM_RANGE - 1) && in_p == PW'(NUM_PULSE - 1)));

endmodule

// File: rtl/ct_read_path.sv
module ct_read_path
    import ct_pkg::*;
#(
    parameter int NUM_RANGE = 4096,
    parameter int NUM_PULSE = 512,
    parameter int OUT_DEPTH = 4,
    parameter int ADDR_W    = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                bank_ready,
    input  logic [ADDR_W-1:0]   bank_base,
    output logic                release_o,
    output logic                rd_valid,
    input  logic                rd_ready,
    output logic [ADDR_W-1:0]   rd_addr,
    input  logic                rsp_valid,
    input  logic [SAMPLE_W-1:0] rsp_data,
    output logic                out_valid,
    input  logic                out_ready,
    output logic [SAMPLE_W-1:0] out_data,
    output logic                out_sob,
    output logic                out_eof,
    output logic                frame_done
);

    localparam int FRAME = NUM_RANGE * NUM_PULSE;
    localparam int RW    = idx_w(NUM_RANGE);
    localparam int PW    = idx_w(NUM_PULSE);
    localparam int FW    = idx_w(FRAME);
    localparam int OCW   = $clog2(OUT_DEPTH + 1);
    localparam int PTW   = idx_w(OUT_DEPTH);

    logic [PW-1:0]  rq_p;
    logic [RW-1:0]  rq_r;
    logic [FW-1:0]  rq_off;
    logic           rq_done;
    logic [PW-1:0]  rs_p;
    logic [RW-1:0]  rs_r;
    logic [OCW-1:0] outst;
    logic [OCW-1:0] occ;
    logic [PTW-1:0] wptr;
    logic [PTW-1:0] rptr;
    out_word_t      fifo [OUT_DEPTH];
    out_word_t      head;
    out_word_t      push_word;
    logic           credit_ok;
    logic           issue;
    logic           pop;
    logic           last_rsp;

    always_comb begin
        credit_ok = ({1'b0, occ} + {1'b0, outst}) < (OCW + 1)'(OUT_DEPTH);
        rd_valid  = bank_ready && !rq_done && credit_ok;
        rd_addr   = bank_base + ADDR_W'(rq_off);
        issue     = rd_valid && rd_ready;
        last_rsp  = (rs_p == PW'(NUM_PULSE - 1)) && (rs_r == RW'(NUM_RANGE - 1));
        release_o = rsp_valid && last_rsp;
        push_word.s   = iq_t'(rsp_data);
        push_word.sob = (rs_p == '0);
        push_word.eof = last_rsp;
        head      = fifo[rptr];
        out_valid = (occ != '0);
        out_data  = head.s;
        out_sob   = head.sob;
        out_eof   = head.eof;
        pop       = out_valid && out_ready;
    end

    always_ff @(posedge clk) begin
        if (rsp_valid) begin
            fifo[wptr] <= push_word;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rq_p       <= '0;
            rq_r       <= '0;
            rq_off     <= '0;
            rq_done    <= 1'b0;
            rs_p       <= '0;
            rs_r       <= '0;
            outst      <= '0;
            occ        <= '0;
            wptr       <= '0;
            rptr       <= '0;
            frame_done <= 1'b0;
        end else begin
            frame_done <= release_o;
            if (issue) begin
                if (rq_p == PW'(NUM_PULSE - 1)) begin
                    rq_p <= '0;
                    if (rq_r == RW'(NUM_RANGE - 1)) begin
                        rq_r    <= '0;
                        rq_off  <= '0;
                        rq_done <= 1'b1;
                    end else begin
                        rq_r   <= rq_r + 1'b1;
                        rq_off <= FW'(rq_r) + 1'b1;
                    end
                end else begin
                    rq_p   <= rq_p + 1'b1;
                    rq_off <= rq_off + FW'(NUM_RANGE);
                end
            end
            if (release_o) begin
                rq_done <= 1'b0;
            end
            if (rsp_valid) begin
                wptr <= (wptr == PTW'(OUT_DEPTH - 1)) ? '0 : wptr + 1'b1;
                if (rs_p == PW'(NUM_PULSE - 1)) begin
                    rs_p <= '0;
                    rs_r <= (rs_r == RW'(NUM_RANGE - 1)) ? '0 : rs_r + 1'b1;
                end else begin
                    rs_p <= rs_p + 1'b1;
                end
            end
            if (pop) begin
                rptr <= (rptr == PTW'(OUT_DEPTH - 1)) ? '0 : rptr + 1'b1;
            end
            outst <= outst + OCW'(issue) - OCW'(rsp_valid);
            occ   <= occ + OCW'(rsp_valid) - OCW'(pop);
        end
    end

    // R8
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        ({1'b0, occ} + {1'b0, outst}) <= (OCW + 1)'(OUT_DEPTH));

    // R8
    out_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_eof)));

    // R4
    rsp_expect_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> (outst != '0));

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        frame_done |=> !frame_done);

endmodule

// File: rtl/corner_turn_ctrl.sv
module corner_turn_ctrl
    import ct_pkg::*;
#(
    parameter int                NUM_RANGE = 4096,
    parameter int                NUM_PULSE = 512,
    parameter int                BURST_LEN = 16,
    parameter int                OUT_DEPTH = 4,
    parameter int                ADDR_W    = 32,
    parameter logic [ADDR_W-1:0] BASE0     = '0,
    parameter logic [ADDR_W-1:0] BASE1     = ADDR_W'(NUM_RANGE * NUM_PULSE)
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           in_valid,
    output logic                           in_ready,
    input  logic [SAMPLE_W-1:0]            in_data,
    input  logic                           in_sop,
    input  logic                           in_eof,
    output logic                           mem_req_valid,
    input  logic                           mem_req_ready,
    output logic                           mem_req_we,
    output logic                           mem_req_first,
    output logic [$clog2(BURST_LEN+1)-1:0] mem_req_len,
    output logic [ADDR_W-1:0]              mem_req_addr,
    output logic [SAMPLE_W-1:0]            mem_req_wdata,
    input  logic                           mem_rsp_valid,
    input  logic [SAMPLE_W-1:0]            mem_rsp_data,
    output logic                           out_valid,
    input  logic                           out_ready,
    output logic [SAMPLE_W-1:0]            out_data,
    output logic                           out_sob,
    output logic                           out_eof,
    output logic                           frame_done
);

    localparam int LW = $clog2(BURST_LEN + 1);

    logic              commit;
    logic              release_rd;
    logic              wr_bank;
    logic              wr_free;
    logic              rd_bank;
    logic              rd_bank_ready;
    logic [ADDR_W-1:0] wr_base;
    logic [ADDR_W-1:0] rd_base;
    logic              wr_valid;
    logic              wr_ready;
    logic              wr_first;
    logic [LW-1:0]     wr_len;
    logic [ADDR_W-1:0] wr_addr;
    iq_t               wr_data;
    logic              rd_valid;
    logic              rd_ready;
    logic [ADDR_W-1:0] rd_addr;

    always_comb begin
        wr_base = wr_bank ? BASE1 : BASE0;
        rd_base = rd_bank ? BASE1 : BASE0;
        mem_req_valid = wr_valid || rd_valid;
        mem_req_we    = wr_valid;
        mem_req_first = wr_valid ? wr_first : 1'b1;
        mem_req_len   = wr_valid ? wr_len : LW'(1);
        mem_req_addr  = wr_valid ? wr_addr : rd_addr;
        mem_req_wdata = wr_data;
        wr_ready      = mem_req_ready;
        rd_ready      = mem_req_ready && !wr_valid;
    end

    ct_bank_ctrl i_bank (
        .clk       (clk),
        .rst       (rst),
        .commit    (commit),
        .release_i (release_rd),
        .wr_bank   (wr_bank),
        .wr_free   (wr_free),
        .rd_bank   (rd_bank),
        .rd_ready  (rd_bank_ready)
    );

    ct_write_path #(
        .NUM_RANGE (NUM_RANGE),
        .NUM_PULSE (NUM_PULSE),
        .BURST_LEN (BURST_LEN),
        .ADDR_W    (ADDR_W)
    ) i_wr (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_data   (iq_t'(in_data)),
        .in_sop    (in_sop),
        .in_eof    (in_eof),
        .bank_base (wr_base),
        .bank_free (wr_free),
        .commit    (commit),
        .wr_valid  (wr_valid),
        .wr_ready  (wr_ready),
        .wr_first  (wr_first),
        .wr_len    (wr_len),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data)
    );

    ct_read_path #(
        .NUM_RANGE (NUM_RANGE),
        .NUM_PULSE (NUM_PULSE),
        .OUT_DEPTH (OUT_DEPTH),
        .ADDR_W    (ADDR_W)
    ) i_rd (
        .clk        (clk),
        .rst        (rst),
        .bank_ready (rd_bank_ready),
        .bank_base  (rd_base),
        .release_o  (release_rd),
        .rd_valid   (rd_valid),
        .rd_ready   (rd_ready),
        .rd_addr    (rd_addr),
        .rsp_valid  (mem_rsp_valid),
        .rsp_data   (mem_rsp_data),
        .out_valid  (out_valid),
        .out_ready  (out_ready),
        .out_data   (out_data),
        .out_sob    (out_sob),
        .out_eof    (out_eof),
        .frame_done (frame_done)
    );

    // R5
    rd_after_commit_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && !mem_req_we) |-> (rd_bank_ready && mem_req_len == LW'(1)));

endmodule

// File: tb/test_corner_turn_ctrl.sv
module test_corner_turn_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int NR    = 6;
    localparam int NP    = 4;
    localparam int BL    = 4;
    localparam int OD    = 4;
    localparam int AW    = 8;
    localparam int FRAME = NR * NP;
    localparam int B1    = 64;
    localparam int NV    = 4;
    localparam int LW    = $clog2(BL + 1);

    // fields: [19:12] seed, [11:8] input gap modulus, [7:4] output-ready modulus, [3:0] memory-ready mode
    localparam logic [19:0] VEC [NV] = '{20'h11_0_0_0, 20'h2a_3_2_1, 20'h35_0_1_1, 20'h4c_2_0_0};

    logic clk = 1'b0;
    logic rst;
    logic in_valid, in_ready, in_sop, in_eof;
    logic [23:0] in_data;
    logic mem_req_valid, mem_req_ready, mem_req_we, mem_req_first;
    logic [LW-1:0] mem_req_len;
    logic [AW-1:0] mem_req_addr;
    logic [23:0] mem_req_wdata;
    logic mem_rsp_valid;
    logic [23:0] mem_rsp_data;
    logic out_valid, out_ready, out_sob, out_eof, frame_done;
    logic [23:0] out_data;

    int checks = 0, failures = 0;
    int wl = 0, wf = 0, rn = 0, rf = 0, rd_tot = 0;
    int rk = 0, on = 0, pop_tot = 0, fd_cnt = 0, acc_cnt = 0;
    int mem_mode = 0, cyc = 0, ocyc = 0;
    bit hold_out = 1'b0;
    bit finished = 1'b0;

    logic [23:0] mem [256];
    logic p0v, p1v;
    logic [23:0] p0d, p1d;

    always #(CLK_PERIOD / 2) clk = ~clk;

    corner_turn_ctrl #(
        .NUM_RANGE (NR), .NUM_PULSE (NP), .BURST_LEN (BL), .OUT_DEPTH (OD),
        .ADDR_W (AW), .BASE0 (8'd0), .BASE1 (8'(B1))
    ) i_corner_turn_ctrl (
        .clk (clk), .rst (rst),
        .in_valid (in_valid), .in_ready (in_ready), .in_data (in_data),
        .in_sop (in_sop), .in_eof (in_eof),
        .mem_req_valid (mem_req_valid), .mem_req_ready (mem_req_ready),
        .mem_req_we (mem_req_we), .mem_req_first (mem_req_first),
        .mem_req_len (mem_req_len), .mem_req_addr (mem_req_addr),
        .mem_req_wdata (mem_req_wdata),
        .mem_rsp_valid (mem_rsp_valid), .mem_rsp_data (mem_rsp_data),
        .out_valid (out_valid), .out_ready (out_ready), .out_data (out_data),
        .out_sob (out_sob), .out_eof (out_eof), .frame_done (frame_done)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [7:0] seed_of(input int k);
        return (k < NV) ? VEC[k][19:12] : 8'(8'h50 + k);
    endfunction

    function automatic logic [23:0] sval(input int k, input int p, input int r);
        return {seed_of(k), 4'(p), 12'(r * 97 + k * 5)};
    endfunction

    function automatic int base_of(input int k);
        return (k % 2 == 1) ? B1 : 0;
    endfunction

    task automatic send_frame(input int k, input int gap);
        for (int p = 0; p < NP; p++) begin
            for (int r = 0; r < NR; r++) begin
                @(negedge clk);
                in_valid = 1'b1;
                in_data  = sval(k, p, r);
                in_sop   = (r == 0);
                in_eof   = (p == NP - 1) && (r == NR - 1);
                while (!in_ready) @(negedge clk);
                @(posedge clk);
                acc_cnt++;
                if (gap != 0 && (r % gap) == 0) begin
                    @(negedge clk);
                    in_valid = 1'b0;
                end
            end
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_sop   = 1'b0;
        in_eof   = 1'b0;
    endtask

    // memory-ready driver
    always @(negedge clk) begin
        cyc++;
        case (mem_mode)
            0:       mem_req_ready = 1'b1;
            1:       mem_req_ready = (cyc % 3) != 2;
            default: mem_req_ready = 1'b0;
        endcase
    end

    // memory model with monitors
    assign mem_rsp_valid = p1v;
    assign mem_rsp_data  = p1d;
    always @(posedge clk) begin
        if (rst) begin
            p0v <= 1'b0;
            p1v <= 1'b0;
        end else begin
            p1v <= p0v;
            p1d <= p0d;
            p0v <= 1'b0;
            if (mem_req_valid && mem_req_ready) begin
                if (mem_req_we) begin
                    mem[mem_req_addr] <= mem_req_wdata;
                    chk(int'(mem_req_addr) == base_of(wf) + wl, "R2 write address (R6 bank)",
                        int'(mem_req_addr), base_of(wf) + wl);
                    if (mem_req_first)
                        chk(int'(mem_req_len) == ((NR - wl % NR) < BL ? (NR - wl % NR) : BL),
                            "R3 burst length", int'(mem_req_len),
                            (NR - wl % NR) < BL ? (NR - wl % NR) : BL);
                    wl++;
                    if (wl == FRAME) begin
                        wl = 0;
                        wf++;
                    end
                end else begin
                    p0v <= 1'b1;
                    p0d <= mem[mem_req_addr];
                    chk(int'(mem_req_addr) == base_of(rf) + (rn % NP) * NR + rn / NP,
                        "R4 read address", int'(mem_req_addr), base_of(rf) + (rn % NP) * NR + rn / NP);
                    chk(mem_req_len == LW'(1) && mem_req_first, "R4 single-word read", int'(mem_req_len), 1);
                    chk(wf > rf, "R5 read after frame written", wf, rf + 1);
                    rd_tot++;
                    chk(rd_tot - pop_tot <= OD, "R8 read credit bound", rd_tot - pop_tot, OD);
                    rn++;
                    if (rn == FRAME) begin
                        rn = 0;
                        rf++;
                    end
                end
            end
        end
    end

    // output side: drive ready and check transfers
    always @(negedge clk) begin
        ocyc++;
        if (rst || hold_out) begin
            out_ready = 1'b0;
        end else if (rk < NV && VEC[rk][7:4] != 0) begin
            out_ready = (ocyc % (int'(VEC[rk][7:4]) + 1)) != 0;
        end else begin
            out_ready = 1'b1;
        end
        if (!rst && frame_done) fd_cnt++;
        if (!rst && out_valid && out_ready) begin
            chk(out_data == sval(rk, on % NP, on / NP), "R1 output data",
                int'(out_data), int'(sval(rk, on % NP, on / NP)));
            chk(out_data[23:12] == {seed_of(rk), 4'(on % NP)}, "R1 I part position",
                int'(out_data[23:12]), int'({seed_of(rk), 4'(on % NP)}));
            chk(out_sob == (on % NP == 0), "R7 start-of-bin marker", int'(out_sob), int'(on % NP == 0));
            chk(out_eof == (on == FRAME - 1), "R7 end-of-frame marker", int'(out_eof), int'(on == FRAME - 1));
            pop_tot++;
            on++;
            if (on == FRAME) begin
                chk(fd_cnt == rk + 1, "R10 frame_done before eof output", fd_cnt, rk + 1);
                on = 0;
                rk++;
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", rk, 7);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [23:0] held;
        int acc0;
        rst = 1'b1;
        in_valid = 1'b0;
        in_data = '0;
        in_sop = 1'b0;
        in_eof = 1'b0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11 reset state
        chk(in_ready == 1'b1, "R11 in_ready after reset", int'(in_ready), 1);
        chk(mem_req_valid == 1'b0, "R11 mem_req_valid after reset", int'(mem_req_valid), 0);
        chk(out_valid == 1'b0, "R11 out_valid after reset", int'(out_valid), 0);
        chk(frame_done == 1'b0, "R11 frame_done after reset", int'(frame_done), 0);

        // table-driven frames
        for (int k = 0; k < NV; k++) begin
            mem_mode = int'(VEC[k][3:0]);
            send_frame(k, int'(VEC[k][11:8]));
        end
        wait (rk == NV);
        mem_mode = 0;

        // R6 / R8: both frame areas occupied with output held
        hold_out = 1'b1;
        send_frame(4, 0);
        send_frame(5, 0);
        wait (wf == 6);
        repeat (10) @(negedge clk);
        chk(in_ready == 1'b0, "R6 input stalled with both areas full", int'(in_ready), 0);
        chk(rd_tot == NV * FRAME + OD, "R8 reads limited under output stall", rd_tot, NV * FRAME + OD);
        chk(out_valid == 1'b1, "R8 output pending under stall", int'(out_valid), 1);
        held = out_data;
        repeat (5) @(negedge clk);
        chk(out_data == held && out_valid, "R8 output held stable", int'(out_data), int'(held));
        hold_out = 1'b0;

        // R9: memory port refuses beats
        wait (fd_cnt == 5);
        @(negedge clk);
        mem_mode = 2;
        acc0 = acc_cnt;
        fork
            send_frame(6, 0);
        join_none
        repeat (40) @(negedge clk);
        chk(acc_cnt - acc0 == BL, "R9 samples accepted while memory stalled", acc_cnt - acc0, BL);
        chk(in_ready == 1'b0, "R9 in_ready low while memory stalled", int'(in_ready), 0);
        mem_mode = 0;
        wait (rk == 7);
        repeat (5) @(negedge clk);
        chk(fd_cnt == 7, "R10 frame_done count", fd_cnt, 7);
        chk(wf == 7, "R2 frames fully written", wf, 7);
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule